// File: doc/BRIEF.md
# Serial Unsigned Magnitude Comparator

This block decides the relative order of two unsigned binary numbers that arrive one bit pair per clock, most significant bit first. A two-bit state records one of three outcomes: still equal, first operand smaller, or first operand larger. The first bit position at which the operands differ settles the outcome. That outcome then stays fixed until a synchronous clear starts a new comparison. The state is decoded into three one-hot flags.

The same cell equations are also chained across a parameterised vector width to give a purely combinational comparator. This second view takes whole operands and must give the answer the serial view reaches after it has been fed the same operands from the top bit down. A typical use: pulse the clear, present one bit pair per cycle with the valid qualifier high, and read the flags on the cycle after the last pair.

Top module: `serial_mag_cmp`

## Requirements
- R1: When `clr` is high at a rising clock edge, the serial state returns to equal, so that after the edge `eq`=1 and `lt`=`gt`=0.
- R2: When `clr` is low and `bit_vld` is low at an edge, the serial flags keep their values, whatever `x_bit` and `y_bit` are.
- R3: In the equal state, a valid pair with `x_bit`=`y_bit` (both 0 or both 1) leaves the flags at equal.
- R4: In the equal state, a valid pair with `x_bit`=0 and `y_bit`=1 makes `lt`=1 after that edge.
- R5: In the equal state, a valid pair with `x_bit`=1 and `y_bit`=0 makes `gt`=1 after that edge.
- R6: Once `lt` or `gt` is set, later valid pairs of any value leave it set until a clear.
- R7: Exactly one of `lt`, `eq`, `gt` is high in every cycle after the first clear, and the same holds for `vec_lt`, `vec_eq`, `vec_gt`.
- R8: If `clr` and `bit_vld` are both high at one edge, the clear wins and the flags show equal afterwards.
- R9: `vec_lt`, `vec_eq` and `vec_gt` show, within the same cycle, whether `vec_x` is less than, equal to or greater than `vec_y` as unsigned VEC_W-bit numbers.
- R10: After a clear followed by VEC_W valid pairs taken from bit VEC_W-1 down to bit 0 of two operands, the serial flags equal the vector flags for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear; restarts the comparison at equal |
| bit_vld | input | 1 | Qualifies the current bit pair; the state moves only when high |
| x_bit | input | 1 | Current bit of the first operand |
| y_bit | input | 1 | Current bit of the second operand |
| lt | output | 1 | Serial result: first operand is smaller |
| eq | output | 1 | Serial result: operands are equal so far |
| gt | output | 1 | Serial result: first operand is larger |
| vec_x | input | VEC_W | First operand of the combinational view |
| vec_y | input | VEC_W | Second operand of the combinational view |
| vec_lt | output | 1 | Combinational result: `vec_x` < `vec_y` |
| vec_eq | output | 1 | Combinational result: `vec_x` = `vec_y` |
| vec_gt | output | 1 | Combinational result: `vec_x` > `vec_y` |

## Verification
The clear and a valid, differing bit pair can land on the same edge. That collision decides whether a stale decision leaks into the next comparison. The bench presents `clr` together with `bit_vld` and a differing pair, both from the equal state and from an already locked state. A cycle-accurate behavioural model, in which the clear takes priority, judges the flags on the following cycle. The bench also feeds random operand pairs through the serial path and compares the final flags against the combinational view driven with the same operands.

// File: rtl/magcmp_pkg.sv
`timescale 1ns/1ps
package magcmp_pkg;

    // Two-bit comparison code {a, b}: also the carry between cascaded cells
    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_LT  = 2'b01,
        CMP_GT  = 2'b10,
        CMP_BAD = 2'b11
    } cmp_code_e;

    typedef struct packed {
        cmp_code_e code;
    } ser_regs_t;

endpackage

// File: rtl/cmp_cell.sv
`timescale 1ns/1ps
module cmp_cell
    import magcmp_pkg::*;
(
    input  cmp_code_e state_i,
    input  logic      x_i,
    input  logic      y_i,
    output cmp_code_e state_o
);

    logic a_q;
    logic b_q;
    logic a_d;
    logic b_d;

    always_comb begin
        a_q = state_i[1];
        b_q = state_i[0];
        // a sets on x=1,y=0 unless already less; b sets on x=0,y=1 unless already greater
        a_d = a_q | (x_i & ~y_i & ~b_q);
        b_d = b_q | (~x_i & y_i & ~a_q);
        if (a_q && b_q) begin
            state_o = CMP_EQ;
        end else begin
            state_o = cmp_code_e'({a_d, b_d});
        end
    end

endmodule

// File: rtl/cmp_decode.sv
`timescale 1ns/1ps
module cmp_decode
    import magcmp_pkg::*;
(
    input  cmp_code_e code_i,
    output logic      lt_o,
    output logic      eq_o,
    output logic      gt_o
);

    always_comb begin
        lt_o = 1'b0;
        eq_o = 1'b0;
        gt_o = 1'b0;
        unique case (code_i)
            CMP_LT:  lt_o = 1'b1;
            CMP_GT:  gt_o = 1'b1;
            default: eq_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmp_iter.sv
`timescale 1ns/1ps
module cmp_iter
    import magcmp_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] opx_i,
    input  logic [VEC_W-1:0] opy_i,
    output logic             lt_o,
    output logic             eq_o,
    output logic             gt_o
);

    localparam int LINKS = VEC_W + 1;

    cmp_code_e chain [LINKS];

    assign chain[VEC_W] = CMP_EQ;

    // Top bit is processed first; state ripples toward bit 0
    for (genvar gi = 0; gi < VEC_W; gi++) begin : g_cell
        cmp_cell u_cell (
            .state_i (chain[gi+1]),
            .x_i     (opx_i[gi]),
            .y_i     (opy_i[gi]),
            .state_o (chain[gi])
        );
    end

    cmp_decode u_dec (
        .code_i (chain[0]),
        .lt_o   (lt_o),
        .eq_o   (eq_o),
        .gt_o   (gt_o)
    );

    always_comb begin
        // R9
        iter_match_chk: assert ({lt_o, eq_o, gt_o} ==
            ((opx_i < opy_i) ? 3'b100 : (opx_i == opy_i) ? 3'b010 : 3'b001));
        // R7
        iter_onehot_chk: assert ($countones({lt_o, eq_o, gt_o}) == 1);
    end

endmodule

// File: rtl/serial_mag_cmp.sv
`timescale 1ns/1ps
module serial_mag_cmp
    import magcmp_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             x_bit,
    input  logic             y_bit,
    output logic             lt,
    output logic             eq,
    output logic             gt,
    input  logic [VEC_W-1:0] vec_x,
    input  logic [VEC_W-1:0] vec_y,
    output logic             vec_lt,
    output logic             vec_eq,
    output logic             vec_gt
);

    ser_regs_t regs_d;
    ser_regs_t regs_q;
    cmp_code_e step_code;

    cmp_cell u_step (
        .state_i (regs_q.code),
        .x_i     (x_bit),
        .y_i     (y_bit),
        .state_o (step_code)
    );

    always_comb begin
        regs_d = regs_q;
        if (clr) begin
            regs_d.code = CMP_EQ;
        end else if (regs_q.code == CMP_BAD) begin
            regs_d.code = CMP_EQ;
        end else if (bit_vld) begin
            regs_d.code = step_code;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    cmp_decode u_dec (
        .code_i (regs_q.code),
        .lt_o   (lt),
        .eq_o   (eq),
        .gt_o   (gt)
    );

    cmp_iter #(.VEC_W(VEC_W)) u_iter (
        .opx_i (vec_x),
        .opy_i (vec_y),
        .lt_o  (vec_lt),
        .eq_o  (vec_eq),
        .gt_o  (vec_gt)
    );

    // R1
    clr_to_eq_chk: assert property (@(posedge clk)
        clr |=> (eq && !lt && !gt));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !bit_vld |=> $stable({lt, eq, gt}));

    // R4
    first_less_chk: assert property (@(posedge clk) disable iff (clr)
        (eq && bit_vld && !x_bit && y_bit) |=> lt);

    // R5
    first_greater_chk: assert property (@(posedge clk) disable iff (clr)
        (eq && bit_vld && x_bit && !y_bit) |=> gt);

    // R6
    lock_lt_chk: assert property (@(posedge clk) disable iff (clr)
        lt |=> lt);

    // R6
    lock_gt_chk: assert property (@(posedge clk) disable iff (clr)
        gt |=> gt);

    // R7
    flag_onehot_chk: assert property (@(posedge clk) disable iff (clr)
        $countones({lt, eq, gt}) == 1);

    // R7
    code_legal_chk: assert property (@(posedge clk) disable iff (clr)
        regs_q.code != CMP_BAD);

endmodule

// File: tb/serial_mag_cmp_bench.sv
`timescale 1ns/1ps
module serial_mag_cmp_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         bit_vld = 1'b0;
    logic         x_bit = 1'b0;
    logic         y_bit = 1'b0;
    logic         lt, eq, gt;
    logic [W-1:0] vec_x = '0;
    logic [W-1:0] vec_y = '0;
    logic         vec_lt, vec_eq, vec_gt;

    int vectors = 0;
    int fails   = 0;
    int ref_st  = 0;   // 0 equal, 1 less, 2 greater
    bit done    = 1'b0;

    always #2 clk = ~clk;

    serial_mag_cmp #(.VEC_W(W)) u_serial_mag_cmp (
        .clk(clk), .clr(clr), .bit_vld(bit_vld), .x_bit(x_bit), .y_bit(y_bit),
        .lt(lt), .eq(eq), .gt(gt),
        .vec_x(vec_x), .vec_y(vec_y),
        .vec_lt(vec_lt), .vec_eq(vec_eq), .vec_gt(vec_gt)
    );

    function automatic logic [2:0] flags_of(input int st);
        return (st == 1) ? 3'b100 : (st == 2) ? 3'b001 : 3'b010;
    endfunction

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got {lt,eq,gt}=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic v, input logic xb, input logic yb,
                        input string tag);
        @(negedge clk);
        clr = c; bit_vld = v; x_bit = xb; y_bit = yb;
        @(posedge clk);
        if (c) ref_st = 0;
        else if (v && ref_st == 0 && xb != yb) ref_st = xb ? 2 : 1;
        #1;
        chk(tag, {lt, eq, gt}, flags_of(ref_st));
        chk("R7", {1'b0, 1'b0, ($countones({lt, eq, gt}) == 1)}, 3'b001);
    endtask

    task automatic vec_check(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        vec_x = a; vec_y = b;
        #1;
        chk("R9", {vec_lt, vec_eq, vec_gt},
            (a < b) ? 3'b100 : (a == b) ? 3'b010 : 3'b001);
    endtask

    task automatic feed(input logic [W-1:0] a, input logic [W-1:0] b);
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        for (int i = W - 1; i >= 0; i--) step(1'b0, 1'b1, a[i], b[i], "R6");
        vec_check(a, b);
        chk("R10", {lt, eq, gt}, {vec_lt, vec_eq, vec_gt});
    endtask

    initial begin
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R3: equal pairs keep equal
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R3");
        // R2: invalid differing pair ignored in equal state
        step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
        // R4
        step(1'b0, 1'b1, 1'b0, 1'b1, "R4");
        // R6 absorbing less
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
        // R8: clear with a valid differing pair from a locked state
        step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
        // R5
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        // R8 again, then from equal
        step(1'b1, 1'b1, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R2");
        // R9/R10 boundary operands
        feed('0, '0);
        feed('1, '1);
        feed('1, {W{1'b1}} - 1'b1);
        feed({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}});
        feed(8'h01, 8'h00);
        for (int n = 0; n < 60; n++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = (n % 4 == 0) ? a : W'($urandom);
            feed(a, b);
        end
        for (int n = 0; n < 100; n++) vec_check(W'($urandom), W'($urandom));
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule